// File: doc/BRIEF.md
# One-Wire Byte CRC-8 Checker

This block computes the 8-bit checksum used on single-wire device buses over a stream of bytes. A byte is taken on every cycle where `valid_i` is high. The running checksum is kept in a register and shown on `crc_o`. A clear strobe starts a new message.

The checksum is the reflected form of x^8+x^5+x^4+1. The register starts at zero, and there is no final inversion. Each step looks up (or computes) a result from the running value XOR the incoming byte. One whole byte is absorbed per clock.

`crc_zero_o` is high whenever the running value is zero. A device identifier or data frame is checked by feeding all of its bytes, including the trailing checksum byte, and then testing that single flag. The block has no part in bus timing, framing, or choosing which bytes are covered.

Top module: `onewire_crc8_chk`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `crc_o` is 0x00 and `crc_zero_o` is 1 until a byte is absorbed.
- R2: On a clock edge with `valid_i` high and `clear_i` low, the next `crc_o` is found as follows. Take the current `crc_o` XOR `data_i`. Shift that value right 8 times, LSB first. Each time the bit shifted out is 1, XOR the shifted value with 0x8C. The result is visible the cycle after the byte.
- R3: Starting from zero, a single byte gives these results: 0x01 gives 0x5E, 0x02 gives 0xBC, 0x03 gives 0xE2, 0x80 gives 0x8C, 0xFF gives 0x35, and 0x00 gives 0x00.
- R4: On a clock edge with both `valid_i` and `clear_i` low, `crc_o` keeps its value whatever `data_i` holds.
- R5: On a clock edge with `clear_i` high and `valid_i` low, `crc_o` becomes 0x00.
- R6: On a clock edge with `clear_i` and `valid_i` both high, `crc_o` becomes the checksum of `data_i` alone, starting from zero.
- R7: `crc_zero_o` is 1 exactly when `crc_o` is 0x00. After a message has been absorbed, absorbing its own checksum byte sets it to 1.
- R8: The bytes of a message are absorbed in arrival order, one per valid cycle. Idle cycles between them do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Restart the checksum from zero |
| valid_i | input | 1 | `data_i` holds a byte to absorb |
| data_i | input | 8 | Incoming byte |
| crc_o | output | 8 | Running checksum |
| crc_zero_o | output | 1 | Running checksum equals zero |

## Verification
Four properties are checked on every cycle:
- a valid byte lands as the step result in the next cycle;
- an idle cycle holds the register;
- a lone clear empties it;
- feeding a byte equal to the current checksum always yields zero.

Whether the step result is the right polynomial can only be shown by the bench's scenarios. The bench sweeps every single-byte value from zero and compares each against an arithmetic model. It also runs long multi-byte messages with idle gaps and combined clear-and-valid cycles. After each message it appends the message's own checksum byte.

// File: rtl/owcrc_pkg.sv
package owcrc_pkg;
  localparam int unsigned CRC_W = 8;
  localparam int unsigned LUT_N = 1 << CRC_W;
  typedef logic [CRC_W-1:0] crc_t;

  // eight LSB-first shifts of a pre-mixed value
  function automatic crc_t crc_shift_byte(crc_t idx, crc_t poly);
    crc_t r;
    r = idx;
    for (int b = 0; b < CRC_W; b++) begin
      if (r[0]) r = (r >> 1) ^ poly;
      else      r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/crc8_index.sv
module crc8_index
  import owcrc_pkg::*;
(
  input  crc_t crc_i,
  input  crc_t data_i,
  input  logic clear_i,
  output crc_t idx_o
);
  // clear folds into the index: the old state is treated as zero
  always_comb begin
    if (clear_i) idx_o = data_i;
    else         idx_o = crc_i ^ data_i;
  end
endmodule

// File: rtl/crc8_step.sv
module crc8_step
  import owcrc_pkg::*;
#(
  parameter bit   USE_LUT = 1'b1,
  parameter crc_t POLY    = 8'h8C
) (
  input  crc_t idx_i,
  output crc_t nxt_o
);
  if (USE_LUT) begin : g_lut
    crc_t lut [LUT_N];
    for (genvar i = 0; i < LUT_N; i++) begin : g_ent
      assign lut[i] = crc_shift_byte(crc_t'(i), POLY);
    end
    assign nxt_o = lut[idx_i];
  end else begin : g_bitwise
    always_comb nxt_o = crc_shift_byte(idx_i, POLY);
  end
endmodule

// File: rtl/crc8_state.sv
module crc8_state
  import owcrc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic valid_i,
  input  crc_t nxt_i,
  output crc_t crc_o
);
  crc_t crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (valid_i) crc_q <= nxt_i;
    else if (clear_i) crc_q <= '0;
  end

  assign crc_o = crc_q;

  AST_ABSORB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> crc_q == $past(nxt_i)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> $stable(crc_q)); // R4
  AST_CLEAR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !valid_i) |=> crc_q == '0); // R5
endmodule

// File: rtl/onewire_crc8_chk.sv
module onewire_crc8_chk
  import owcrc_pkg::*;
#(
  parameter bit   USE_LUT = 1'b1,
  parameter crc_t POLY    = 8'h8C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o,
  output logic       crc_zero_o
);
  crc_t crc_w, idx_w, nxt_w;

  crc8_index u_index (
    .crc_i  (crc_w),
    .data_i (data_i),
    .clear_i(clear_i),
    .idx_o  (idx_w)
  );

  crc8_step #(.USE_LUT(USE_LUT), .POLY(POLY)) u_step (
    .idx_i(idx_w),
    .nxt_o(nxt_w)
  );

  crc8_state u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .valid_i(valid_i),
    .nxt_i  (nxt_w),
    .crc_o  (crc_w)
  );

  assign crc_o      = crc_w;
  assign crc_zero_o = (crc_w == '0);

  // feeding the current checksum back as data must empty the register
  AST_SELF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && data_i == crc_o) |=> crc_zero_o); // R7
endmodule

// File: tb/tb_onewire_crc8_chk.sv
module tb_onewire_crc8_chk;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] crc;
  logic       zflag;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  onewire_crc8_chk dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .valid_i(vld),
    .data_i(din), .crc_o(crc), .crc_zero_o(zflag)
  );

  function automatic logic [7:0] ref_step(logic [7:0] c, logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  task automatic check(string req, logic [7:0] exp_crc);
    checks++;
    if (crc !== exp_crc) begin
      errors++;
      $display("FAIL %s: crc_o=%02h expected %02h", req, crc, exp_crc);
    end
    checks++;
    if (zflag !== (exp_crc == 8'h00)) begin
      errors++;
      $display("FAIL R7 (%s): crc_zero_o=%0b expected %0b", req, zflag, exp_crc == 8'h00);
    end
  endtask

  // drive at negedge, posedge captures, check at the next negedge
  task automatic cyc(logic c, logic v, logic [7:0] d, string req);
    clr = c; vld = v; din = d;
    if (v) model = ref_step(c ? 8'h00 : model, d);
    else if (c) model = 8'h00;
    @(negedge clk);
    clr = 1'b0; vld = 1'b0;
    check(req, model);
  endtask

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h00);

    // R3 known single-byte results
    cyc(1'b1, 1'b1, 8'h01, "R3"); check("R3", 8'h5E);
    cyc(1'b1, 1'b1, 8'h02, "R3"); check("R3", 8'hBC);
    cyc(1'b1, 1'b1, 8'h03, "R3"); check("R3", 8'hE2);
    cyc(1'b1, 1'b1, 8'h80, "R3"); check("R3", 8'h8C);
    cyc(1'b1, 1'b1, 8'hFF, "R3"); check("R3", 8'h35);
    cyc(1'b1, 1'b1, 8'h00, "R3"); check("R3", 8'h00);

    // R2 exhaustive single byte from zero, via lone clear then absorb
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, 1'b0, 8'hA5, "R5");
      cyc(1'b0, 1'b1, 8'(i), "R2");
    end

    // R6 exhaustive clear+valid from a nonzero state
    for (int i = 0; i < 256; i++) begin
      cyc(1'b0, 1'b1, 8'h5A, "R2");
      cyc(1'b1, 1'b1, 8'(i), "R6");
    end

    // R4 idle cycles ignore data
    cyc(1'b0, 1'b1, 8'h3C, "R2");
    for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, next_rand(), "R4");

    // R8/R7 messages with gaps, then their own checksum
    for (int m = 0; m < 200; m++) begin
      cyc(1'b1, 1'b0, 8'h00, "R5");
      for (int b = 0; b < 1 + (m % 9); b++) begin
        cyc(1'b0, 1'b1, next_rand(), "R8");
        if (lfsr[8]) cyc(1'b0, 1'b0, next_rand(), "R8");
      end
      cyc(1'b0, 1'b1, model, "R7");
    end

    // R7 fixed 8-byte identifier with trailing checksum
    cyc(1'b1, 1'b0, 8'h00, "R5");
    cyc(1'b0, 1'b1, 8'h02, "R8");
    cyc(1'b0, 1'b1, 8'h1C, "R8");
    cyc(1'b0, 1'b1, 8'hB8, "R8");
    cyc(1'b0, 1'b1, 8'h01, "R8");
    cyc(1'b0, 1'b1, 8'h00, "R8");
    cyc(1'b0, 1'b1, 8'h00, "R8");
    cyc(1'b0, 1'b1, 8'h00, "R8");
    cyc(1'b0, 1'b1, model, "R7");
    check("R7", 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule